// File: doc/BRIEF.md
# Page-Wide Memory Self-Test Engine with Halt on Miscompare

This block tests one memory bank a whole page at a time. A start command runs two passes. The first pass writes a checkerboard page to every address in ascending order. The second pass reads each page back and compares it in one step against the same expected page. Any differing bit is a fault. The engine drives a simple synchronous memory port. A read issued in one cycle returns its page on `mem_rdata_i` in the next cycle.

A mode input is sampled at start. In tally mode the engine never pauses. It counts failing pages and reports the total when the run ends. In halt mode it freezes on each failing page and shows the page address, the failing-bit mask and a fault class. It then waits, with `fail_flag_o` raised, until the controller pulses resume. A status word reports progress and results.

Top module: `pagebist_engine`

## Requirements
- R1: After reset, `status_o` is 0, `fail_flag_o` is 0, `fail_count_o` is 0 and `mem_en_o` is 0.
- R2: The write pass writes every page exactly once. Even page addresses get the word with bit 0 set and bits alternating (`{PAGE_W/2{2'b01}}`). Odd page addresses get its complement.
- R3: The read pass reads every page in ascending order after the write pass. With no miscompare, the run ends with done set, fault-found clear and a count of 0.
- R4: In tally mode (`mode_halt_i`=0 at start) the engine never raises `fail_flag_o`. `fail_count_o` ends equal to the number of failing pages, and the fail address holds the last failing page.
- R5: In halt mode (`mode_halt_i`=1 at start) a miscompare raises `fail_flag_o` and shows `fail_addr_o` and `fail_mask_o` (the XOR of read and expected page). These outputs hold with no memory access until resume.
- R6: `fail_type_o` is 0 when exactly one bit of the page fails and 1 when several bits fail. Codes 2 and 3 never appear.
- R7: Resume clears `fail_flag_o` on the next cycle. Testing continues at the page after the failing one, so no page is read twice.
- R8: A fault on the last page followed by resume ends the run with done set.
- R9: Start clears the count and status. Start is ignored while a run is in progress.
- R10: `status_o` bit 0 is fault-found (sticky per run), bit 1 is done, bit 2 is busy and bit 3 is halted. Done and `fail_flag_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run (accepted when not busy) |
| mode_halt_i | input | 1 | 1 = halt on each fault, 0 = tally mode; sampled at start |
| resume_i | input | 1 | Continue after a halt |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Page address |
| mem_wdata_o | output | PAGE_W | Page write data |
| mem_rdata_i | input | PAGE_W | Page read data, one cycle after the read |
| fail_flag_o | output | 1 | High while halted on an unserved fault |
| fail_addr_o | output | ADDR_W | Latest failing page |
| fail_mask_o | output | PAGE_W | Failing bits of that page |
| fail_type_o | output | 2 | 0 single bit, 1 multiple bits |
| fail_count_o | output | CNT_W | Failing pages this run (saturating) |
| status_o | output | 4 | {halted, busy, done, fault-found} |

## Verification
The hardest situation to reach is a halt-mode run that stops several times, including on the final page. Each stop must be held and then released without a page being re-read. The bench builds this from a memory model that XORs chosen bit masks into reads of chosen pages. It holds the engine halted for many cycles while counting accesses. It also counts reads per page to show that each page is read once across all resumes. Start pulses issued mid-run and after a faulty run cover the ignore and clear behaviour.

// File: rtl/pagebist_engine.sv
module pagebist_engine #(
  parameter int ADDR_W = 4,
  parameter int PAGE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_halt_i,
  input  logic              resume_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PAGE_W-1:0] mem_wdata_o,
  input  logic [PAGE_W-1:0] mem_rdata_i,
  output logic              fail_flag_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [PAGE_W-1:0] fail_mask_o,
  output logic [1:0]        fail_type_o,
  output logic [CNT_W-1:0]  fail_count_o,
  output logic [3:0]        status_o
);
  localparam logic [ADDR_W-1:0] LAST_PAGE = '1;
  localparam logic [PAGE_W-1:0] PAT_EVEN  = {(PAGE_W/2){2'b01}};

  typedef enum logic [2:0] {S_IDLE, S_WRITE, S_READ, S_CMP, S_HALT, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr_q;
  logic              mode_q;
  logic              found_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] faddr_q;
  logic [PAGE_W-1:0] fmask_q;
  logic [1:0]        ftype_q;

  logic [PAGE_W-1:0] expect_w;
  logic [PAGE_W-1:0] diff_w;
  logic              miss_w, multi_w, busy_w;

  assign expect_w = addr_q[0] ? ~PAT_EVEN : PAT_EVEN;
  assign diff_w   = mem_rdata_i ^ expect_w;
  assign miss_w   = |diff_w;
  assign multi_w  = |(diff_w & (diff_w - 1'b1));
  assign busy_w   = (st == S_WRITE) || (st == S_READ) || (st == S_CMP) || (st == S_HALT);

  assign mem_en_o     = (st == S_WRITE) || (st == S_READ);
  assign mem_we_o     = (st == S_WRITE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = expect_w;
  assign fail_flag_o  = (st == S_HALT);
  assign fail_addr_o  = faddr_q;
  assign fail_mask_o  = fmask_q;
  assign fail_type_o  = ftype_q;
  assign fail_count_o = cnt_q;
  assign status_o     = {st == S_HALT, busy_w, st == S_DONE, found_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      mode_q  <= 1'b0;
      found_q <= 1'b0;
      cnt_q   <= '0;
      faddr_q <= '0;
      fmask_q <= '0;
      ftype_q <= 2'd0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            st      <= S_WRITE;
            addr_q  <= '0;
            mode_q  <= mode_halt_i;
            found_q <= 1'b0;
            cnt_q   <= '0;
            faddr_q <= '0;
            fmask_q <= '0;
            ftype_q <= 2'd0;
          end
        end
        S_WRITE: begin
          if (addr_q == LAST_PAGE) begin
            addr_q <= '0;
            st     <= S_READ;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        S_READ: st <= S_CMP;
        S_CMP: begin
          if (miss_w) begin
            found_q <= 1'b1;
            if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            faddr_q <= addr_q;
            fmask_q <= diff_w;
            ftype_q <= multi_w ? 2'd1 : 2'd0;
          end
          if (miss_w && mode_q) begin
            st <= S_HALT;
          end else if (addr_q == LAST_PAGE) begin
            st <= S_DONE;
          end else begin
            addr_q <= addr_q + 1'b1;
            st     <= S_READ;
          end
        end
        S_HALT: begin
          if (resume_i) begin
            if (addr_q == LAST_PAGE) begin
              st <= S_DONE;
            end else begin
              addr_q <= addr_q + 1'b1;
              st     <= S_READ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pagebist_engine_chk.sv
module pagebist_engine_chk #(
  parameter int ADDR_W = 4,
  parameter int PAGE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              resume_i,
  input logic              mode_q,
  input logic              mem_en_o,
  input logic              fail_flag_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [PAGE_W-1:0] fail_mask_o,
  input logic [1:0]        fail_type_o,
  input logic [3:0]        status_o
);
  p_no_access_halted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o |-> !mem_en_o);

  p_coord_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o && !resume_i |=> fail_flag_o && $stable(fail_addr_o) && $stable(fail_mask_o));

  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o |-> fail_mask_o != '0);

  p_type_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o |-> fail_type_o == (($countones(fail_mask_o) == 1) ? 2'd0 : 2'd1));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o && resume_i |=> !fail_flag_o);

  p_tally_nostop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !fail_flag_o);

  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fail_flag_o && status_o[1]));
endmodule

bind pagebist_engine pagebist_engine_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .resume_i(resume_i), .mode_q(mode_q),
  .mem_en_o(mem_en_o), .fail_flag_o(fail_flag_o), .fail_addr_o(fail_addr_o),
  .fail_mask_o(fail_mask_o), .fail_type_o(fail_type_o), .status_o(status_o));

// File: tb/pagebist_engine_tb_top.sv
`timescale 1ns/1ps
module pagebist_engine_tb_top;
  localparam int AW = 4;
  localparam int PW = 16;
  localparam int CW = 16;
  localparam int NP = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, mode = 0, resume = 0;
  logic mem_en, mem_we, fail_flag;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [PW-1:0] mem_wdata, mem_rdata = '0, fail_mask;
  logic [1:0] fail_type;
  logic [CW-1:0] fail_count;
  logic [3:0] status;

  logic [PW-1:0] mem [NP];
  logic [PW-1:0] inj [NP];
  int wrcnt [NP];
  int rdcnt [NP];
  int acc_total = 0;
  bit flag_seen = 0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pagebist_engine #(.ADDR_W(AW), .PAGE_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_halt_i(mode), .resume_i(resume),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .fail_flag_o(fail_flag), .fail_addr_o(fail_addr),
    .fail_mask_o(fail_mask), .fail_type_o(fail_type), .fail_count_o(fail_count),
    .status_o(status));

  always @(posedge clk) begin
    if (fail_flag) flag_seen <= 1;
    if (mem_en) begin
      acc_total <= acc_total + 1;
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wrcnt[mem_addr] <= wrcnt[mem_addr] + 1;
      end else begin
        mem_rdata <= mem[mem_addr] ^ inj[mem_addr];
        rdcnt[mem_addr] <= rdcnt[mem_addr] + 1;
      end
    end
  end

  function automatic logic [PW-1:0] pat(int a);
    return (a % 2 == 1) ? ~{(PW/2){2'b01}} : {(PW/2){2'b01}};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep(bit m);
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      inj[i] = '0; wrcnt[i] = 0; rdcnt[i] = 0; mem[i] = '0;
    end
    flag_seen = 0;
    mode = m;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_evt(output bit ok);
    ok = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (fail_flag || status[1]) begin ok = 1; break; end
    end
  endtask

  task automatic check_reads_once(string req);
    int bad = 0;
    for (int i = 0; i < NP; i++) if (rdcnt[i] != 1) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(status == 4'd0, "R1 status", status, 0);
    chk(!fail_flag, "R1 flag", fail_flag, 0);
    chk(fail_count == 0, "R1 count", fail_count, 0);
    chk(!mem_en, "R1 mem_en", mem_en, 0);
  endtask

  task automatic t_clean();
    bit ok; int badw = 0;
    prep(0);
    pulse_start();
    chk(status[2] == 1, "R10 busy", status, 4);
    wait_evt(ok);
    chk(ok && status == 4'b0010, "R3 done clean", status, 2);
    chk(fail_count == 0, "R3 count", fail_count, 0);
    for (int i = 0; i < NP; i++) if (wrcnt[i] != 1 || mem[i] != pat(i)) badw++;
    chk(badw == 0, "R2 write pass", badw, 0);
    check_reads_once("R3 reads");
  endtask

  task automatic t_tally();
    bit ok;
    prep(0);
    inj[2] = 16'h0004; inj[5] = 16'h0300; inj[15] = 16'h8000;
    pulse_start();
    wait_evt(ok);
    chk(ok && status[1], "R4 done", status, 2);
    chk(!flag_seen, "R4 no stop", flag_seen, 0);
    chk(fail_count == 3, "R4 count", fail_count, 3);
    chk(fail_addr == 15, "R4 last addr", fail_addr, 15);
    chk(status[0], "R10 fault found", status, 1);
  endtask

  task automatic halt_expect(int a, logic [PW-1:0] m, int ty, string tag);
    bit ok;
    wait_evt(ok);
    chk(ok && fail_flag, {tag, " R5 halted"}, fail_flag, 1);
    chk(fail_addr == a, {tag, " R5 addr"}, fail_addr, a);
    chk(fail_mask == m, {tag, " R5 mask"}, fail_mask, m);
    chk(fail_type == ty, {tag, " R6 type"}, fail_type, ty);
    chk(status[3] && !status[1], {tag, " R10 halted bits"}, status, 12);
  endtask

  task automatic do_resume(string tag);
    @(negedge clk) resume = 1;
    @(negedge clk) resume = 0;
    chk(!fail_flag, {tag, " R7 flag cleared"}, fail_flag, 0);
  endtask

  task automatic t_halt();
    bit ok; int acc0;
    prep(1);
    inj[3] = 16'h0010; inj[9] = 16'h0F00; inj[15] = 16'h8000;
    pulse_start();
    halt_expect(3, 16'h0010, 0, "p3");
    acc0 = acc_total;
    repeat (20) @(negedge clk);
    chk(fail_flag && acc_total == acc0, "R5 hold no access", acc_total - acc0, 0);
    chk(fail_addr == 3, "R5 addr held", fail_addr, 3);
    do_resume("p3");
    halt_expect(9, 16'h0F00, 1, "p9");
    do_resume("p9");
    halt_expect(15, 16'h8000, 0, "p15");
    do_resume("p15");
    wait_evt(ok);
    chk(ok && status[1] && !fail_flag, "R8 done after last", status, 2);
    chk(fail_count == 3, "R5 count", fail_count, 3);
    check_reads_once("R7 no reread");
  endtask

  task automatic t_restart();
    bit ok;
    prep(0);
    pulse_start();
    repeat (5) @(negedge clk);
    pulse_start();
    wait_evt(ok);
    chk(ok && status[1], "R9 done", status, 2);
    chk(wrcnt[0] == 1 && wrcnt[1] == 1, "R9 start ignored while busy", wrcnt[0], 1);
    check_reads_once("R9 single run");
    prep(0);
    inj[7] = 16'h0001;
    pulse_start();
    wait_evt(ok);
    chk(fail_count == 1 && status[0], "R9 faulty run", fail_count, 1);
    prep(0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(fail_count == 0 && status[0] == 0 && status[1] == 0, "R9 start clears", {fail_count, status}, 4);
    wait_evt(ok);
    chk(ok && fail_count == 0 && status == 4'b0010, "R9 clean rerun", status, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) begin inj[i] = '0; mem[i] = '0; wrcnt[i] = 0; rdcnt[i] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_tally();
    t_halt();
    t_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule